// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The RAM has one shared data bus and three active-low strobes: chip select, write enable and output enable. The host hands over one access at a time through a valid/ready request port. The sequencer turns each request into the matching strobe pattern and holds every phase for a whole number of clock cycles. Each of those cycle counts is a parameter, worked out by rounding the RAM's nanosecond minimums up to whole clock periods.

A write goes through four phases:
- Setup: select and address only.
- Pulse: write enable low while the sequencer drives the data.
- Hold: the data stays driven for one cycle with write enable high.
- Turnaround: the RAM is deselected.

A read holds select and output enable low for the access count. The data is captured on the edge that ends that count. It comes back as a one-cycle response pulse in the same cycle that both strobes return high. The response port has no ready input, so the host must take `rsp_rdata` in the cycle `rsp_valid` is high. While a request waits, `req_valid` must stay high and the request fields must stay stable. A request is taken on any edge where `req_valid` and `req_ready` are both high.

A retention request is honoured only between accesses. During retention the RAM stays deselected and no request is taken. When the request is released, a recovery interval passes before any access is accepted again.

Top module: `sram_seq`

## Requirements

The requirements use these derived cycle counts:

| Count | Definition | Value with default parameters |
|---|---|---|
| SET | max(T_AS, 1) | 1 |
| PULSE | max(T_WP, T_WHZ+T_DW, T_CW-SET, T_AW-SET) | 15 |
| TURN | max(1, T_WC-SET-PULSE-1) | 1 |
| ACC | max(T_RC, T_AA, T_ACS, T_OE) | 18 |
| REC | T_RC | 18 |

- R1: While reset is held and in the first cycle after it, all three strobes are high (1), `mem_dq_oe` is 0 and `rsp_valid` is 0. `req_ready` equals the inverse of `sleep_req`.
- R2: `req_ready` is high only when no access, retention or recovery is in progress and `sleep_req` is low. After a request is taken, `req_ready` stays low until the access ends:
  - SET+PULSE+1+TURN cycles for a write (`req_write`=1);
  - ACC cycles for a read (`req_write`=0).
- R3: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly ACC cycles, starting in the cycle after acceptance. `mem_dq_oe` stays 0 throughout.
- R4: In the cycle after a read's strobes end, `rsp_valid` is 1 for exactly one cycle. In that cycle `rsp_rdata` holds the byte the RAM presented at the end of the access, and `mem_cs_n` and `mem_oe_n` are back at 1.
- R5: A write, starting in the cycle after acceptance, runs these phases:
  - SET cycles with select low and the other strobes high;
  - exactly PULSE cycles with `mem_cs_n`=0 and `mem_we_n`=0;
  - one cycle with select low and write enable high.

  Write enable is never low while select is high.
- R6: `mem_dq_oe` is 1 only during the PULSE cycles and the single hold cycle after them. While it is 1, `mem_dq_o` carries the accepted write byte. `mem_addr` does not change while `mem_cs_n` stays low.
- R7: `mem_oe_n` is 1 in every cycle in which `mem_dq_oe` is 1, and in the cycle after `mem_dq_oe` falls, so the two bus drivers never overlap.
- R8: With no access in progress, a high `sleep_req` moves the block into retention on the next edge. In retention `sleep_active` is 1, `mem_cs_n` is 1 and `req_ready` is 0. A `sleep_req` raised during an access takes effect only after the access has finished.
- R9: After `sleep_req` falls during retention, `sleep_active` drops on the next edge. `req_ready` then stays 0 for REC further cycles.
- R10: The written byte lands in the RAM. A later read of the same address through R3 and R4 returns it, including at addresses 0x0000 and 0x7FFF.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| sleep_req | input | 1 | Retention request |
| sleep_active | output | 1 | Retention in effect |
| mem_addr | output | 15 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the RAM bus |
| mem_dq_oe | output | 1 | Controller drives the RAM bus |
| mem_dq_i | input | 8 | Byte read from the RAM bus |

## Verification

Every output of this block changes one register stage after the edge that samples its cause. The strobe phases of an accepted request therefore begin in the first cycle after the accepting edge and run for exactly the derived counts in R2–R5. The read response falls in the single cycle after the last access cycle, and the recovery count starts in the cycle after `sleep_active` drops.

The bench keeps a queue of expected per-cycle strobe, drive and ready values. It pushes the queue at the cycle of acceptance and compares it against the ports on each falling edge, when all outputs are settled. A cycle-level RAM model alongside it flags bus contention, short write overlaps and short data setup. It returns valid read data only once select has been low for the read access minimum.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSET    = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_WTURN   = 3'd4,
    ST_RACC    = 3'd5,
    ST_SLEEP   = 3'd6,
    ST_RECOVER = 3'd7
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int SET_C  = 1,
  parameter int PULSE_C = 15,
  parameter int TURN_C = 1,
  parameter int ACC_C  = 18,
  parameter int REC_C  = 18,
  parameter int CNT_W  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic sleep_req,
  output logic req_ready,
  output logic accept,
  output logic rd_capture,
  output logic sleep_active,
  output logic mem_cs_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_oe
);

  localparam logic [CNT_W-1:0] SET_LD   = CNT_W'(SET_C - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_C - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_C - 1);
  localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_C - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_C - 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign req_ready  = (state_q == ST_IDLE) && !sleep_req;
  assign accept     = req_ready && req_valid;
  assign rd_capture = (state_q == ST_RACC) && tmr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_SLEEP;
        end else if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSET;
            tmr_val = SET_LD;
          end else begin
            state_d = ST_RACC;
            tmr_val = ACC_LD;
          end
        end
      end
      ST_WSET: if (tmr_done) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
      end
      ST_WPULSE: if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD: begin
        state_d  = ST_WTURN;
        tmr_load = 1'b1;
        tmr_val  = TURN_LD;
      end
      ST_WTURN: if (tmr_done) state_d = ST_IDLE;
      ST_RACC:  if (tmr_done) state_d = ST_IDLE;
      ST_SLEEP: if (!sleep_req) begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_cs_n     = !((state_q == ST_WSET) || (state_q == ST_WPULSE) ||
                          (state_q == ST_WHOLD) || (state_q == ST_RACC));
  assign mem_we_n     = (state_q != ST_WPULSE);
  assign mem_oe_n     = (state_q != ST_RACC);
  assign mem_dq_oe    = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign sleep_active = (state_q == ST_SLEEP);

  // length of the current write-enable low run, for the pulse-width check
  logic [CNT_W:0] we_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_run <= '0;
    else if (!mem_we_n) we_low_run <= we_low_run + 1'b1;
    else                we_low_run <= '0;
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n); // R5
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run == (CNT_W+1)'(PULSE_C))); // R5
  AST_DRIVE_STARTS_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n); // R6
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> mem_oe_n); // R7
  AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> (mem_cs_n && !req_ready)); // R8
  AST_RECOVERY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_active) |-> !req_ready); // R9

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_rdata <= mem_dq_i;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_cs_n); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R6

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int T_RC   = 18,
  parameter int T_AA   = 18,
  parameter int T_ACS  = 18,
  parameter int T_OE   = 10,
  parameter int T_WC   = 18,
  parameter int T_WP   = 13,
  parameter int T_CW   = 15,
  parameter int T_AW   = 15,
  parameter int T_AS   = 0,
  parameter int T_DW   = 8,
  parameter int T_WHZ  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sleep_req,
  output logic              sleep_active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int SET_C   = imax(T_AS, 1);
  localparam int PULSE_C = imax(imax(T_WP, T_WHZ + T_DW),
                                imax(imax(T_CW - SET_C, T_AW - SET_C), 1));
  localparam int TURN_C  = imax(1, T_WC - SET_C - PULSE_C - 1);
  localparam int ACC_C   = imax(imax(T_RC, T_AA), imax(imax(T_ACS, T_OE), 1));
  localparam int REC_C   = imax(T_RC, 1);
  localparam int MAX_C   = imax(imax(imax(SET_C, PULSE_C), imax(TURN_C, ACC_C)), REC_C);
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic accept;
  logic rd_capture;

  sram_seq_fsm #(
    .SET_C   (SET_C),
    .PULSE_C (PULSE_C),
    .TURN_C  (TURN_C),
    .ACC_C   (ACC_C),
    .REC_C   (REC_C),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .sleep_req    (sleep_req),
    .req_ready    (req_ready),
    .accept       (accept),
    .rd_capture   (rd_capture),
    .sleep_active (sleep_active),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_dq_oe    (mem_dq_oe)
  );

  sram_seq_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_i   (mem_dq_i),
    .mem_cs_n   (mem_cs_n),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/sram_seq_tb.sv
module sram_seq_tb;

  localparam int T_RC = 18, T_AA = 18, T_ACS = 18, T_OE = 10, T_WC = 18;
  localparam int T_WP = 13, T_CW = 15, T_AW = 15, T_AS = 0, T_DW = 8, T_WHZ = 7;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SET   = mx(T_AS, 1);
  localparam int PULSE = mx(mx(T_WP, T_WHZ + T_DW), mx(T_CW - SET, T_AW - SET));
  localparam int TURN  = mx(1, T_WC - SET - PULSE - 1);
  localparam int ACC   = mx(mx(T_RC, T_AA), mx(T_ACS, T_OE));
  localparam int REC   = T_RC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sleep_active;
  logic [7:0] rsp_rdata, mem_dq_o;
  logic [14:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] mem_dq_i = 8'h00;

  always #2 clk = ~clk;

  sram_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sleep_req(sleep_req), .sleep_active(sleep_active),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // ---------------- expected-cycle reference ----------------
  typedef struct {
    logic [3:0] strobes; // {cs_n, we_n, oe_n, dq_oe}
    logic [7:0] data;
    bit         rd_last;
    string      tag;
  } cyc_t;

  cyc_t q[$];
  logic [7:0] ref_mem [int];
  int mode = 0;          // 0 idle, 1 retention, 2 recovery
  int rec_left = 0;
  bit rsp_now = 0;
  logic [7:0] rsp_exp = 8'h00;

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
  endfunction

  task automatic push_write(input logic [7:0] d);
    for (int i = 0; i < SET; i++)   q.push_back('{4'b0110, d, 1'b0, "R5 setup"});
    for (int i = 0; i < PULSE; i++) q.push_back('{4'b0011, d, 1'b0, "R5 pulse"});
    q.push_back('{4'b0111, d, 1'b0, "R6 hold"});
    for (int i = 0; i < TURN; i++)  q.push_back('{4'b1110, d, 1'b0, "R2 turn"});
  endtask

  task automatic push_read(input logic [7:0] d);
    for (int i = 0; i < ACC; i++) q.push_back('{4'b0100, d, (i == ACC - 1), "R3 read"});
  endtask

  // ---------------- cycle-level RAM model ----------------
  logic [7:0] sram [int];
  int rd_run = 0, w_run = 0, d_run = 0, cs_run = 0;
  logic [14:0] w_addr;
  logic [7:0]  w_last;
  bit in_ovl = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      // RAM side: bus contention, write window, read drive
      if (!mem_cs_n && !mem_oe_n && mem_we_n && mem_dq_oe)
        chk("R7 bus contention", 1, 0);
      cs_run = mem_cs_n ? 0 : cs_run + 1;
      if (!mem_cs_n && !mem_we_n) begin
        if (in_ovl && mem_addr != w_addr) chk("R6 address moved in write", mem_addr, w_addr);
        if (!in_ovl) begin w_addr = mem_addr; w_run = 0; d_run = 0; end
        in_ovl = 1;
        w_run++;
        d_run = mem_dq_oe ? d_run + 1 : 0;
        w_last = mem_dq_o;
      end else if (in_ovl) begin
        in_ovl = 0;
        chk("R5 overlap too short", (w_run >= T_WP), 1);
        chk("R6 data setup too short", (d_run >= T_DW), 1);
        sram[int'(w_addr)] = w_last;
      end
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        rd_run++;
        mem_dq_i = (rd_run >= T_ACS) ?
          (sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : init_byte(int'(mem_addr))) : 8'hC3;
      end else begin
        rd_run = 0;
        mem_dq_i = 8'hC3;
      end

      // reference comparison for this cycle
      begin
        logic [3:0] exp_s;
        logic exp_rdy, exp_sl;
        bit nxt_rsp;
        exp_s = 4'b1110; exp_rdy = 0; exp_sl = 0; nxt_rsp = 0;
        if (q.size() > 0) begin
          exp_s = q[0].strobes;
          chk(q[0].tag, {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, exp_s);
          if (q[0].strobes[0]) chk("R6 drive data", mem_dq_o, q[0].data);
        end else begin
          if (mode == 1) exp_sl = 1;
          if (mode == 0) exp_rdy = !sleep_req;
          chk(mode == 1 ? "R8 retention strobes" : "R1 idle strobes",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, exp_s);
        end
        chk(mode == 2 ? "R9 recovery ready" : "R2 ready", req_ready, exp_rdy);
        chk("R8 sleep_active", sleep_active, exp_sl);
        chk("R4 rsp_valid", rsp_valid, rsp_now);
        if (rsp_now) chk("R4 R10 rsp_rdata", rsp_rdata, rsp_exp);

        // advance the reference
        if (q.size() > 0) begin
          cyc_t e;
          e = q.pop_front();
          if (e.rd_last) begin nxt_rsp = 1; rsp_exp = e.data; end
        end else if (mode == 1) begin
          if (!sleep_req) begin mode = 2; rec_left = REC; end
        end else if (mode == 2) begin
          rec_left--;
          if (rec_left == 0) mode = 0;
        end else if (sleep_req) begin
          mode = 1;
        end else if (req_valid) begin
          if (req_write) begin
            push_write(req_wdata);
            ref_mem[int'(req_addr)] = req_wdata;
          end else begin
            push_read(ref_rd(int'(req_addr)));
          end
        end
        rsp_now = nxt_rsp;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    idle_cycles(3);
    // R1: outputs during reset
    @(negedge clk);
    chk("R1 reset strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    @(posedge clk); #1;
    rst_n = 1;
    idle_cycles(2);

    // R5 R6 R10: writes at both ends of the address range
    issue(1, 15'h0000, 8'h3C);
    issue(1, 15'h7FFF, 8'hFF);
    issue(1, 15'h1234, 8'h00);
    // R3 R4 R10: read back, plus an unwritten address
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    issue(0, 15'h1234, 8'h00);
    issue(0, 15'h0100, 8'h00);
    idle_cycles(3);
    // overwrite and read back after a gap
    issue(1, 15'h1234, 8'hA5);
    idle_cycles(2);
    issue(0, 15'h1234, 8'h00);

    // R8 R9: retention from idle, with a request waiting during it
    idle_cycles(2);
    sleep_req = 1;
    idle_cycles(4);
    req_valid = 1; req_write = 0; req_addr = 15'h7FFF;
    idle_cycles(6);
    sleep_req = 0;
    issue(0, 15'h7FFF, 8'h00);

    // R8: retention requested in the middle of a write
    req_valid = 1; req_write = 1; req_addr = 15'h0042; req_wdata = 8'h81;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    idle_cycles(3);
    sleep_req = 1;
    idle_cycles(25);
    sleep_req = 0;
    idle_cycles(REC + 4);
    issue(0, 15'h0042, 8'h00);
    idle_cycles(30);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule